// File: doc/BRIEF.md
# Multi-Character Confirmed Word Aligner

This block takes a serial bit stream that arrives one bit per clock from an already recovered clock. It cuts the stream into 10-bit characters. A free-running phase counter produces a character event every ten clocks, and this phase is never moved. Alignment is changed only by choosing which ten bits of a 19-bit history window form the character. Because the strobe cadence never stretches or shrinks, a clock derived from it can be passed on to other logic without phase hops.

At every character event the block searches all ten bit offsets for a 7-bit comma prefix, in either disparity form. A single sighting does not move the boundary. In pair mode, a second sighting at the same offset must follow within a 50-bit span. In run mode, the comma must arrive on four back-to-back characters at one offset. With the enable low, the committed offset is frozen. A framed flag rises at the first commit and stays high.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted, and straight after it, char_stb and framed are 0 and char_out is all zeros. The committed offset starts at 0, so the first characters are bits 0..9, 10..19, ... counted from the first clock after reset.
- R2: char_stb pulses for one clock every 10 clocks, in the cycle after each character event. char_out holds 10 consecutive stream bits, with the earliest received bit in char_out[9]. It is cut at the committed offset, and the strobe cadence never changes.
- R3: A comma is a 10-bit window whose first seven bits (char_out[9:3] order) equal the comma pattern 0011111 or its complement 1100000. Both forms count alike.
- R4: A single comma sighting never changes the committed offset.
- R5: In pair mode (mode_sel=0), a second comma at the same offset, on a character at most 4 characters after the first (a span of at most 50 bits), commits that offset.
- R6: In pair mode, a second comma 5 characters after the first (a span of 60 bits) does not commit. The earlier sighting has expired.
- R7: In run mode (mode_sel=1), four comma characters in a row at the same offset commit it. Three in a row followed by a non-comma character do not commit.
- R8: While align_en is 0, the committed offset does not change, whatever commas arrive.
- R9: A commit made at a character event applies from the next char_stb onward. framed goes to 1 at the first commit and stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit, one per clock |
| align_en | input | 1 | 1 allows the boundary to move |
| mode_sel | input | 1 | 0 = pair within 50 bits, 1 = four consecutive |
| char_out | output | 10 | Aligned character, earliest bit in bit 9 |
| char_stb | output | 1 | One-clock pulse marking a new char_out |
| framed | output | 1 | High once any offset has been committed |

## Verification
A wrong committed offset, or a commit made at the wrong moment, shows on char_out at the very next strobe. Every character after that is a rotated slice of the stream and disagrees with a model cut at the expected offset. A candidate counter that keeps a stale sighting, or that forgets to expire it, commits one or two characters too early in the window and run scenarios. Those wrong slices appear within ten clocks of the offending comma. A phase counter fault breaks the strobe spacing at the next event.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int CHAR_W = 10;
  localparam int PFX_W  = 7;
  localparam int HIST_W = 2 * CHAR_W - 1;
  localparam int OFS_W  = $clog2(CHAR_W);

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [HIST_W-1:0] hist_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [PFX_W-1:0]  pfx_t;

  typedef enum logic {
    CONF_PAIR = 1'b0,
    CONF_RUN  = 1'b1
  } conf_mode_e;

  // Ten bits of the history starting at offset o; hist[0] is the newest bit.
  function automatic char_t slice_at(hist_t h, ofs_t o);
    hist_t s;
    s = h >> o;
    return s[CHAR_W-1:0];
  endfunction

  // Leading seven bits match the comma or its complement.
  function automatic logic prefix_hit(char_t c, pfx_t pat);
    return (c[CHAR_W-1 -: PFX_W] == pat) || (c[CHAR_W-1 -: PFX_W] == ~pat);
  endfunction

  // Last character that still lies in the span after a counted sighting.
  function automatic int span_chars(int span_bits);
    return span_bits / CHAR_W - 1;
  endfunction
endpackage

// File: rtl/wa_shifter.sv
module wa_shifter
  import wa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_in,
  output hist_t hist,
  output logic  stb_evt
);
  logic [HIST_W-2:0] sr;
  ofs_t              ph;

  assign hist    = {sr, bit_in};
  assign stb_evt = (ph == ofs_t'(CHAR_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      ph <= '0;
    end else begin
      sr <= hist[HIST_W-2:0];
      ph <= stb_evt ? '0 : ph + 1'b1;
    end
  end
endmodule

// File: rtl/wa_scan.sv
module wa_scan
  import wa_pkg::*;
#(
  parameter pfx_t COMMA_PAT = 7'b0011111
) (
  input  hist_t hist,
  output logic  hit,
  output ofs_t  hit_ofs
);
  logic [CHAR_W-1:0] hit_vec;

  for (genvar k = 0; k < CHAR_W; k++) begin : g_ofs
    assign hit_vec[k] = prefix_hit(slice_at(hist, ofs_t'(k)), COMMA_PAT);
  end

  // Lowest offset wins when several windows match.
  always_comb begin
    hit_ofs = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_ofs = ofs_t'(k);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/wa_confirm.sv
module wa_confirm
  import wa_pkg::*;
#(
  parameter int SPAN_BITS = 50,
  parameter int PAIR_N    = 2,
  parameter int RUN_N     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_evt,
  input  logic hit,
  input  ofs_t hit_ofs,
  input  logic align_en,
  input  logic mode_sel,
  output ofs_t cur_ofs,
  output logic framed,
  output logic commit
);
  localparam int MAX_DIST = span_chars(SPAN_BITS);
  localparam int CNT_MAX  = (PAIR_N > RUN_N) ? PAIR_N : RUN_N;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int AGE_W    = $clog2(MAX_DIST + 2);

  conf_mode_e       mode;
  ofs_t             cand_ofs;
  logic [CNT_W-1:0] cand_cnt, cnt_nx;
  logic [AGE_W-1:0] cand_age, age_nx;
  logic             same_ofs, in_win, extend, expire;
  int               need;

  assign mode     = conf_mode_e'(mode_sel);
  assign need     = (mode == CONF_RUN) ? RUN_N : PAIR_N;
  assign age_nx   = cand_age + 1'b1;
  assign same_ofs = hit && (cand_cnt != '0) && (hit_ofs == cand_ofs);
  assign in_win   = (mode == CONF_RUN) ? (age_nx == AGE_W'(1))
                                       : (int'(age_nx) <= MAX_DIST);
  assign extend   = same_ofs && in_win;
  assign expire   = !in_win;
  assign cnt_nx   = extend ? cand_cnt + 1'b1 : (hit ? CNT_W'(1) : '0);
  assign commit   = stb_evt && align_en && hit && (int'(cnt_nx) >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_ofs <= '0;
      cand_cnt <= '0;
      cand_age <= '0;
      cur_ofs  <= '0;
      framed   <= 1'b0;
    end else if (stb_evt) begin
      if (!align_en) begin
        cand_cnt <= '0;
        cand_age <= '0;
      end else if (commit) begin
        cur_ofs  <= hit_ofs;
        framed   <= 1'b1;
        cand_cnt <= '0;
        cand_age <= '0;
      end else if (hit) begin
        cand_ofs <= hit_ofs;
        cand_cnt <= cnt_nx;
        cand_age <= '0;
      end else if (cand_cnt != '0) begin
        if (expire) begin
          cand_cnt <= '0;
          cand_age <= '0;
        end else begin
          cand_age <= age_nx;
        end
      end
    end
  end
endmodule

// File: rtl/wa_output.sv
module wa_output
  import wa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stb_evt,
  input  hist_t hist,
  input  ofs_t  cur_ofs,
  output char_t char_out,
  output logic  char_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_out <= '0;
      char_stb <= 1'b0;
    end else begin
      char_stb <= stb_evt;
      if (stb_evt) char_out <= slice_at(hist, cur_ofs);
    end
  end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import wa_pkg::*;
#(
  parameter pfx_t COMMA_PAT = 7'b0011111,
  parameter int   SPAN_BITS = 50,
  parameter int   PAIR_N    = 2,
  parameter int   RUN_N     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              align_en,
  input  logic              mode_sel,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_stb,
  output logic              framed
);
  hist_t hist;
  logic  stb_evt;
  logic  scan_hit;
  ofs_t  scan_ofs;
  ofs_t  cur_ofs;
  logic  commit;

  wa_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .hist    (hist),
    .stb_evt (stb_evt)
  );

  wa_scan #(.COMMA_PAT(COMMA_PAT)) u_scan (
    .hist    (hist),
    .hit     (scan_hit),
    .hit_ofs (scan_ofs)
  );

  wa_confirm #(
    .SPAN_BITS (SPAN_BITS),
    .PAIR_N    (PAIR_N),
    .RUN_N     (RUN_N)
  ) u_conf (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_evt  (stb_evt),
    .hit      (scan_hit),
    .hit_ofs  (scan_ofs),
    .align_en (align_en),
    .mode_sel (mode_sel),
    .cur_ofs  (cur_ofs),
    .framed   (framed),
    .commit   (commit)
  );

  wa_output u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_evt  (stb_evt),
    .hist     (hist),
    .cur_ofs  (cur_ofs),
    .char_out (char_out),
    .char_stb (char_stb)
  );
endmodule

// File: rtl/wa_checker.sv
module wa_checker
  import wa_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic align_en,
  input logic char_stb,
  input logic framed,
  input logic stb_evt,
  input logic scan_hit,
  input logic commit,
  input ofs_t cur_ofs
);
  logic [3:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (char_stb) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 4'hF) begin
      gap <= gap + 1'b1;
    end
  end

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (char_stb && seen) |-> (gap == 4'(CHAR_W - 1))); // R2
  AST_STB_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    stb_evt |=> char_stb); // R2
  AST_COMMIT_AT_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (stb_evt && scan_hit && align_en)); // R3
  AST_OFS_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cur_ofs)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en |=> $stable(cur_ofs)); // R8
  AST_FRAMED_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> framed); // R9
  AST_FRAMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    framed |=> framed); // R9
endmodule

bind comma_word_aligner wa_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .align_en (align_en),
  .char_stb (char_stb),
  .framed   (framed),
  .stb_evt  (stb_evt),
  .scan_hit (scan_hit),
  .commit   (commit),
  .cur_ofs  (cur_ofs)
);

// File: tb/tb_comma_word_aligner.sv
module tb_comma_word_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       align_en = 1'b1;
  logic       mode_sel = 1'b0;
  logic [9:0] char_out;
  logic       char_stb;
  logic       framed;

  localparam logic [9:0] COMMA  = 10'b0011111010;
  localparam logic [9:0] NCOMMA = 10'b1100000101;

  always #4 clk = ~clk;

  comma_word_aligner dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .align_en (align_en),
    .mode_sel (mode_sel),
    .char_out (char_out),
    .char_stb (char_stb),
    .framed   (framed)
  );

  int total = 0;
  int bad = 0;
  logic bits [0:8191];
  int nb = 0;
  logic last_bit = 1'b0;
  int exp_ofs = 0;
  int pend_ofs = 0;
  int pend_edge = -1;
  int phase_r = 0;
  int mism = 0;
  logic [9:0] first_act = '0;
  logic [9:0] first_exp = '0;
  int fc = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [9:0] model_char(int e, int o);
    logic [9:0] c;
    for (int i = 0; i < 10; i++) c[9-i] = bits[e - o - 9 + i];
    return c;
  endfunction

  // Drive one bit, wait for the edge that samples it, then check any strobe.
  task automatic send_bit(input logic b);
    int e;
    logic [9:0] m;
    bit_in = b;
    bits[nb] = b;
    last_bit = b;
    nb++;
    @(negedge clk);
    if (char_stb) begin
      e = nb - 1;
      if (pend_edge >= 0 && e > pend_edge) begin
        exp_ofs = pend_ofs;
        pend_edge = -1;
      end
      if (e - exp_ofs - 9 >= 0) begin
        m = model_char(e, exp_ofs);
        if (m !== char_out) begin
          if (mism == 0) begin
            first_act = char_out;
            first_exp = m;
          end
          mism++;
        end
      end
    end
  endtask

  task automatic send_char(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic slip(input int n);
    for (int i = 0; i < n; i++) send_bit(~last_bit);
    phase_r = (phase_r + n) % 10;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) begin
      case (fc % 3)
        0: send_char(10'b1101000110);
        1: send_char(10'b0110001011);
        default: send_char(10'b0101010101);
      endcase
      fc++;
    end
  endtask

  // Comma expected to complete a qualifying sequence: predict the switch.
  task automatic send_confirm(input logic [9:0] c);
    int s;
    s = nb;
    pend_edge = s + 9 + (9 - ((s + 9) % 10));
    pend_ofs = (10 - phase_r) % 10;
    send_char(c);
  endtask

  task automatic chk_slices(input string req);
    check(mism == 0, req, int'(first_act), int'(first_exp));
    mism = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(char_stb == 1'b0, "R1 char_stb", int'(char_stb), 0);
    check(framed == 1'b0, "R1 framed", int'(framed), 0);
    check(char_out == 10'd0, "R1 char_out", int'(char_out), 0);
    rst_n = 1'b1;
    fill(4);
    chk_slices("R1 R2 initial slices");
  endtask

  task automatic t_lone_comma;
    mode_sel = 1'b0;
    slip(3);
    send_char(COMMA);
    fill(8);
    chk_slices("R4 lone comma slices");
    check(framed == 1'b0, "R4 framed", int'(framed), 0);
  endtask

  task automatic t_pair_edge;
    send_char(COMMA);
    fill(3);
    send_confirm(COMMA);
    fill(6);
    chk_slices("R5 R9 pair at 50 bits");
    check(framed == 1'b1, "R9 framed set", int'(framed), 1);
    check(exp_ofs == 7, "R5 model offset", exp_ofs, 7);
  endtask

  task automatic t_pair_expired;
    slip(4);
    send_char(COMMA);
    fill(4);
    send_char(COMMA);
    fill(6);
    chk_slices("R6 pair at 60 bits");
    check(framed == 1'b1, "R9 framed held", int'(framed), 1);
  endtask

  task automatic t_disabled;
    align_en = 1'b0;
    slip(2);
    send_char(COMMA);
    send_char(NCOMMA);
    send_char(COMMA);
    fill(4);
    chk_slices("R8 disabled commas");
    align_en = 1'b1;
    fill(2);
  endtask

  task automatic t_run_mode;
    mode_sel = 1'b1;
    slip(3);
    send_char(COMMA);
    send_char(COMMA);
    send_char(COMMA);
    fill(4);
    chk_slices("R7 three then break");
    send_char(NCOMMA);
    send_char(NCOMMA);
    send_char(NCOMMA);
    send_confirm(NCOMMA);
    fill(5);
    chk_slices("R7 R3 four complement commas");
    check(exp_ofs == 8, "R7 model offset", exp_ofs, 8);
    check(framed == 1'b1, "R9 framed run", int'(framed), 1);
  endtask

  initial begin
    t_reset;
    t_lone_comma;
    t_pair_edge;
    t_pair_expired;
    t_disabled;
    t_run_mode;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule